// File: doc/BRIEF.md
# Phase-Shifted PWM Gate Generator for a Three-Phase Cascaded H-Bridge

This block turns three signed per-phase voltage references into the switch gate pattern of a star-connected cascaded H-bridge inverter. The inverter has three series H-bridge modules in each phase. All three modules of a phase share one reference. Each module compares that reference with its own triangular carrier. The three carriers have one common period and are spaced one third of a period apart, so the steps of the phase voltage interleave.

Inside a bridge the modulation is unipolar. Leg A compares the reference with the carrier, and leg B compares the negated reference with the same carrier. Each leg drives a complementary pair of gates, and a programmable blanking interval separates the turn-off of one gate from the turn-on of the other.

A controller writes a new reference per phase into a shadow register. It then pulses a load strobe, and the shadow values move into the active registers at the next carrier turning point. An enable input and a trip input together decide whether any gate may conduct.

Top module: `chb_pspwm`

Each leg runs a small state machine with four states:
- `LEG_SAFE`: both gates are off. This is the state after reset and whenever operation is not permitted.
- `LEG_BLANK`: both gates are off while the dead-time count runs.
- `LEG_UPPER`: the upper gate is on.
- `LEG_LOWER`: the lower gate is on.

The leg state machine has these transitions:
- SAFE→BLANK: operation becomes permitted.
- UPPER→BLANK: the leg command drops.
- LOWER→BLANK: the leg command rises.
- BLANK→UPPER or BLANK→LOWER: the blanking count is complete. The next state follows the leg command.
- any→SAFE: operation is not permitted.

The reference bank runs a second state machine:
- `LOAD_IDLE`→`LOAD_ARMED`: a load strobe arrives.
- `LOAD_ARMED`→`LOAD_IDLE`: a turning point is reached and the copy happens. If another strobe arrives in that same cycle, the machine stays in `LOAD_ARMED`.

## Requirements
- R1: While reset is asserted, and while `enable` is low, all 36 gates are low.
- R2: The master carrier count starts at 0 on the first clock after reset and wraps after 2·HALF_PERIOD clocks. Module m's carrier runs m·(2·HALF_PERIOD/3) counts ahead of module 0. As a result, the leg-A upper-gate rising edges of modules 0, 1 and 2 precede each other by 16 and 32 cycles (mod 48) with defaults, and each repeats every 48 cycles.
- R3: The carrier value is 2·tri−(HALF_PERIOD−1), where tri is the triangular fold of the count into the range 0..HALF_PERIOD−1. Leg A is commanded high when ref > carrier. Leg B is commanded high when −ref > carrier. With a zero reference, the two legs of every module carry identical gates.
- R4: Over a reference sweep, the phase level Σ(A_hi − B_hi) over the three modules takes all seven values from −3 to +3.
- R5: With a constant mid-range reference, the phase level changes three times as often per carrier period as one module's level: 12 changes against 4 with defaults.
- R6: A write with `ref_sel` equal to 0, 1 or 2 goes to that phase's shadow register. A write with `ref_sel` = 3 changes no register.
- R7: Shadow values reach the active registers only after a load strobe, and only at the next turning point (count 0 or HALF_PERIOD). With a strobe sampled at count 5, the leg-A upper gate of a module at full positive reference that is switched to full negative is still high at count 25 and low at count 26.
- R8: A written reference beyond ±HALF_PERIOD is clamped to that limit. Positive overrange keeps every A-upper and B-lower gate on for the whole period. Negative overrange keeps every A-lower and B-upper gate on.
- R9: The two gates of a leg are never high together. Each changeover holds both gates low for exactly max(`dead_cycles`, 1) clocks.
- R10: `trip` forces all gates low from the next clock and holds them low while it stays high. After it clears, every leg passes through blanking before exactly one gate per leg turns on.
- Gate index: (phase·3 + module)·4 + s, where s = 0 is the A upper gate, 1 is the A lower gate, 2 is the B upper gate and 3 is the B lower gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits gate conduction |
| trip | input | 1 | Forces all gates off while high |
| ref_wr | input | 1 | Shadow register write strobe |
| ref_sel | input | 2 | Phase selected for the write |
| ref_data | input | 16 | Signed reference value |
| ref_load | input | 1 | Arms the shadow-to-active transfer |
| dead_cycles | input | 8 | Blanking length in clocks |
| gates | output | 36 | Gate drive outputs |

## Verification
The hardest situation to reach from the ports is the exact cycle in which a staged reference takes effect. That cycle depends on the hidden carrier count. The bench keeps its own count of clock edges since reset release and uses it to place the load strobe at count 5. It then checks the gate at counts 25 and 26 across the transfer. The interleaving of the three carriers is observed in the same way, through the spacing of gate edges and the count of phase-level changes over one period.

// File: rtl/chb_pwm_pkg.sv
package chb_pwm_pkg;

    // State of one half-bridge leg.
    typedef enum logic [1:0] {
        LEG_SAFE  = 2'd0,
        LEG_BLANK = 2'd1,
        LEG_UPPER = 2'd2,
        LEG_LOWER = 2'd3
    } leg_state_e;

    // State of the reference transfer sequencer.
    typedef enum logic {
        LOAD_IDLE  = 1'b0,
        LOAD_ARMED = 1'b1
    } load_state_e;

    // Gate slots within one module.
    localparam int SW_PER_MOD = 4;
    localparam int SW_A_HI    = 0;
    localparam int SW_A_LO    = 1;
    localparam int SW_B_HI    = 2;
    localparam int SW_B_LO    = 3;

endpackage

// File: rtl/chb_carrier_gen.sv
module chb_carrier_gen
    import chb_pwm_pkg::*;
#(
    parameter int HALF  = 24,
    parameter int MODS  = 3,
    parameter int CAR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic signed [CAR_W-1:0] car_o [MODS],
    output logic                    turn_o
);

    localparam int PERIOD = 2 * HALF;
    localparam int CW     = $clog2(PERIOD);
    localparam int SHIFT  = PERIOD / MODS;

    logic [CW-1:0] ph_q;

    // Master count: 0 .. PERIOD-1, then wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ph_q == CW'(PERIOD - 1))
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    // Valley at count 0, peak at count HALF.
    assign turn_o = (ph_q == '0) || (ph_q == CW'(HALF));

    // One folded triangle per module, each offset by an equal share of the period.
    for (genvar j = 0; j < MODS; j++) begin : g_car
        always_comb begin : fold
            int t;
            int tv;
            t = int'(ph_q) + j * SHIFT;
            if (t >= PERIOD)
                t = t - PERIOD;
            tv = (t < HALF) ? t : (PERIOD - 1 - t);
            car_o[j] = CAR_W'(2 * tv - (HALF - 1));
        end
    end

    assert_count_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == CW'(PERIOD - 1)) |=> (ph_q == '0));

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ph_q) < PERIOD);

endmodule

// File: rtl/chb_ref_bank.sv
module chb_ref_bank
    import chb_pwm_pkg::*;
#(
    parameter int PHASES = 3,
    parameter int REF_W  = 16,
    parameter int HALF   = 24,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic signed [REF_W-1:0] data_i,
    input  logic                    load_i,
    input  logic                    turn_i,
    output logic signed [REF_W-1:0] act_o [PHASES]
);

    logic signed [REF_W-1:0] shadow_q [PHASES];
    logic signed [REF_W-1:0] clip;
    load_state_e             st_q, st_d;
    logic                    xfer;

    // Clamp the incoming value to the carrier amplitude.
    always_comb begin
        if (int'(data_i) > HALF)
            clip = REF_W'(HALF);
        else if (int'(data_i) < -HALF)
            clip = REF_W'(-HALF);
        else
            clip = data_i;
    end

    // Transfer sequencer: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= LOAD_IDLE;
        else
            st_q <= st_d;
    end

    // Transfer sequencer: next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LOAD_IDLE:  if (load_i) st_d = LOAD_ARMED;
            LOAD_ARMED: if (turn_i) st_d = load_i ? LOAD_ARMED : LOAD_IDLE;
            default:    st_d = LOAD_IDLE;
        endcase
    end

    // Transfer sequencer: output.
    always_comb begin
        unique case (st_q)
            LOAD_ARMED: xfer = turn_i;
            default:    xfer = 1'b0;
        endcase
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_ph
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_q[p] <= '0;
            else if (wr_i && (int'(sel_i) == p))
                shadow_q[p] <= clip;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                act_o[p] <= '0;
            else if (xfer)
                act_o[p] <= shadow_q[p];
        end

        assert_active_moves_at_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !turn_i |=> $stable(act_o[p]));

        assert_shadow_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(shadow_q[p]) <= HALF) && (int'(shadow_q[p]) >= -HALF));
    end

endmodule

// File: rtl/chb_leg_driver.sv
module chb_leg_driver
    import chb_pwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            cmd_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            g_hi_o,
    output logic            g_lo_o
);

    leg_state_e      st_q, st_d;
    logic [DT_W-1:0] cnt_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= LEG_SAFE;
        else
            st_q <= st_d;
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d = LEG_SAFE;
        end else begin
            unique case (st_q)
                LEG_SAFE:  st_d = LEG_BLANK;
                LEG_UPPER: if (!cmd_i) st_d = LEG_BLANK;
                LEG_LOWER: if (cmd_i)  st_d = LEG_BLANK;
                LEG_BLANK: if (cnt_q >= dead_i) st_d = cmd_i ? LEG_UPPER : LEG_LOWER;
                default:   st_d = LEG_SAFE;
            endcase
        end
    end

    // Blanking counter: held at 1 outside the blank state, so the blank lasts max(dead,1) clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= DT_W'(1);
        else if (st_q != LEG_BLANK)
            cnt_q <= DT_W'(1);
        else if (cnt_q < dead_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Outputs.
    always_comb begin
        g_hi_o = 1'b0;
        g_lo_o = 1'b0;
        unique case (st_q)
            LEG_UPPER: g_hi_o = 1'b1;
            LEG_LOWER: g_lo_o = 1'b1;
            default:   ;
        endcase
    end

    assert_upper_after_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_hi_o) |-> $past(!g_hi_o && !g_lo_o));

    assert_lower_after_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_lo_o) |-> $past(!g_hi_o && !g_lo_o));

    assert_stop_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!g_hi_o && !g_lo_o));

endmodule

// File: rtl/chb_pspwm.sv
module chb_pspwm
    import chb_pwm_pkg::*;
#(
    parameter int PHASES      = 3,
    parameter int MODS        = 3,
    parameter int HALF_PERIOD = 24,
    parameter int REF_W       = 16,
    parameter int DT_W        = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic                            trip,
    input  logic                            ref_wr,
    input  logic [$clog2(PHASES)-1:0]       ref_sel,
    input  logic signed [REF_W-1:0]         ref_data,
    input  logic                            ref_load,
    input  logic [DT_W-1:0]                 dead_cycles,
    output logic [PHASES*MODS*SW_PER_MOD-1:0] gates
);

    localparam int SEL_W = $clog2(PHASES);
    localparam int CAR_W = $clog2(HALF_PERIOD) + 3;

    logic signed [CAR_W-1:0] car [MODS];
    logic signed [REF_W-1:0] act_ref [PHASES];
    logic                    turn;
    logic                    run;

    assign run = enable && !trip;

    chb_carrier_gen #(
        .HALF  (HALF_PERIOD),
        .MODS  (MODS),
        .CAR_W (CAR_W)
    ) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .car_o  (car),
        .turn_o (turn)
    );

    chb_ref_bank #(
        .PHASES (PHASES),
        .REF_W  (REF_W),
        .HALF   (HALF_PERIOD),
        .SEL_W  (SEL_W)
    ) u_refs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ref_wr),
        .sel_i  (ref_sel),
        .data_i (ref_data),
        .load_i (ref_load),
        .turn_i (turn),
        .act_o  (act_ref)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        for (genvar m = 0; m < MODS; m++) begin : g_mod
            localparam int BASE = (p * MODS + m) * SW_PER_MOD;
            logic cmd_a, cmd_b;

            // Unipolar comparison: leg A against +ref, leg B against -ref, one shared carrier.
            assign cmd_a = int'(act_ref[p]) > int'(car[m]);
            assign cmd_b = -int'(act_ref[p]) > int'(car[m]);

            chb_leg_driver #(.DT_W(DT_W)) u_leg_a (
                .clk    (clk),
                .rst_n  (rst_n),
                .run_i  (run),
                .cmd_i  (cmd_a),
                .dead_i (dead_cycles),
                .g_hi_o (gates[BASE + SW_A_HI]),
                .g_lo_o (gates[BASE + SW_A_LO])
            );

            chb_leg_driver #(.DT_W(DT_W)) u_leg_b (
                .clk    (clk),
                .rst_n  (rst_n),
                .run_i  (run),
                .cmd_i  (cmd_b),
                .dead_i (dead_cycles),
                .g_hi_o (gates[BASE + SW_B_HI]),
                .g_lo_o (gates[BASE + SW_B_LO])
            );
        end
    end

    assert_trip_clears_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (gates == '0));

    assert_disable_clears_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gates == '0));

endmodule

// File: tb/chb_pspwm_test.sv
module chb_pspwm_test;

    localparam int PH   = 3;
    localparam int MD   = 3;
    localparam int HALF = 24;
    localparam int PER  = 2 * HALF;
    localparam int REFW = 16;
    localparam int DTW  = 8;
    localparam int NG   = PH * MD * 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   enable = 1'b0;
    logic                   trip = 1'b0;
    logic                   ref_wr = 1'b0;
    logic                   ref_load = 1'b0;
    logic [1:0]             ref_sel = '0;
    logic signed [REFW-1:0] ref_data = '0;
    logic [DTW-1:0]         dead = '0;
    logic [NG-1:0]          gates;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    chb_pspwm #(
        .PHASES(PH), .MODS(MD), .HALF_PERIOD(HALF), .REF_W(REFW), .DT_W(DTW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trip(trip),
        .ref_wr(ref_wr), .ref_sel(ref_sel), .ref_data(ref_data),
        .ref_load(ref_load), .dead_cycles(dead), .gates(gates)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) edges <= edges + 1;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int g(input int p, input int m, input int s);
        return int'(gates[(p * MD + m) * 4 + s]);
    endfunction

    function automatic int mlvl(input int p, input int m);
        return g(p, m, 0) - g(p, m, 2);
    endfunction

    function automatic int plvl(input int p);
        int s = 0;
        for (int m = 0; m < MD; m++) s += mlvl(p, m);
        return s;
    endfunction

    function automatic int phm();
        return edges % PER;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_ref(input int p, input int v);
        @(negedge clk);
        ref_wr = 1'b1;
        ref_sel = 2'(p);
        ref_data = REFW'(v);
        @(negedge clk);
        ref_wr = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ref_load = 1'b1;
        @(negedge clk);
        ref_load = 1'b0;
    endtask

    task automatic set_all(input int v);
        for (int p = 0; p < PH; p++) put_ref(p, v);
        pulse_load();
    endtask

    // R1: reset and disable keep every gate off.
    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check("R1 gates during reset", $countones(gates), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(6);
        check("R1 gates with enable low", $countones(gates), 0);
    endtask

    // R3: zero reference gives matching legs, one pulse per period.
    task automatic t_zero_ref();
        int mism = 0;
        int rises = 0;
        int prev;
        dead = 8'd2;
        enable = 1'b1;
        idle(2 * PER);
        prev = g(0, 0, 0);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            for (int p = 0; p < PH; p++)
                for (int m = 0; m < MD; m++)
                    if (g(p, m, 0) != g(p, m, 2) || g(p, m, 1) != g(p, m, 3)) mism++;
            if (prev == 0 && g(0, 0, 0) == 1) rises++;
            prev = g(0, 0, 0);
        end
        check("R3 zero ref legs A and B equal", mism, 0);
        check("R3 zero ref leg A rises once per period", rises, 1);
    endtask

    // R6, R7: writes without a load do nothing; selector 3 is ignored.
    task automatic t_shadow();
        int nz = 0;
        int other = 0;
        put_ref(0, 12);
        idle(2 * PER);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (mlvl(0, 0) != 0) nz++;
        end
        check("R7 write without load has no effect", nz, 0);
        put_ref(3, 20);
        pulse_load();
        idle(2 * PER);
        nz = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (mlvl(0, 0) != 0) nz++;
            for (int p = 1; p < PH; p++)
                for (int m = 0; m < MD; m++)
                    if (mlvl(p, m) != 0) other++;
        end
        check("R7 load applies staged phase 0 value", (nz > 0) ? 1 : 0, 1);
        check("R6 selector 3 leaves phases 1 and 2 at zero", other, 0);
    endtask

    // R8 and R7: saturation and the exact transfer cycle.
    task automatic t_sat_sync();
        int full = 0;
        set_all(500);
        idle(2 * PER);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            for (int p = 0; p < PH; p++)
                for (int m = 0; m < MD; m++)
                    if (g(p, m, 0) == 1 && g(p, m, 3) == 1) full++;
        end
        check("R8 positive overrange clamps to full on", full, PER * PH * MD);

        put_ref(0, -500);
        while (phm() != 5) @(negedge clk);
        ref_load = 1'b1;
        @(negedge clk);
        ref_load = 1'b0;
        while (phm() != 25) @(negedge clk);
        check("R7 A upper held through count 25", g(0, 0, 0), 1);
        @(negedge clk);
        check("R7 A upper released at count 26", g(0, 0, 0), 0);

        idle(2 * PER);
        full = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            for (int m = 0; m < MD; m++)
                if (g(0, m, 1) == 1 && g(0, m, 2) == 1) full++;
        end
        check("R8 negative overrange clamps to full off", full, PER * MD);
    endtask

    // R4: a sweep of references visits all seven phase levels.
    task automatic t_levels();
        int seen[7];
        int bad = 0;
        int n = 0;
        int l;
        for (int k = 0; k < 7; k++) seen[k] = 0;
        for (int v = -22; v <= 22; v += 4) begin
            set_all(v);
            for (int i = 0; i < PER + HALF; i++) begin
                @(negedge clk);
                l = plvl(0);
                if (l < -3 || l > 3) bad++;
                else seen[l + 3] = 1;
            end
        end
        for (int k = 0; k < 7; k++) n += seen[k];
        check("R4 distinct phase levels", n, 7);
        check("R4 levels outside -3..3", bad, 0);
    endtask

    // R5 and R2: interleaving and carrier offsets at a mid reference.
    task automatic t_ripple_shift();
        int pc = 0;
        int mc = 0;
        int pp;
        int pm;
        int r[MD];
        int r0b = -1;
        int prv[MD];
        set_all(12);
        idle(2 * PER);
        pp = plvl(0);
        pm = mlvl(0, 0);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (plvl(0) != pp) pc++;
            if (mlvl(0, 0) != pm) mc++;
            pp = plvl(0);
            pm = mlvl(0, 0);
        end
        check("R5 phase level changes per period", pc, 12);
        check("R5 module level changes per period", mc, 4);

        for (int m = 0; m < MD; m++) begin
            r[m] = -1;
            prv[m] = g(0, m, 0);
        end
        for (int i = 0; i < 2 * PER; i++) begin
            @(negedge clk);
            for (int m = 0; m < MD; m++) begin
                if (prv[m] == 0 && g(0, m, 0) == 1) begin
                    if (r[m] < 0) r[m] = i;
                    else if (m == 0 && r0b < 0) r0b = i;
                end
                prv[m] = g(0, m, 0);
            end
        end
        check("R2 module 1 leads module 0", ((r[0] - r[1]) % PER + PER) % PER, 16);
        check("R2 module 2 leads module 0", ((r[0] - r[2]) % PER + PER) % PER, 32);
        check("R2 carrier period", r0b - r[0], PER);
    endtask

    task automatic measure_blank(input int from_s, input int to_s, output int k);
        int prev = g(0, 0, from_s);
        int lim = 0;
        while (!(prev == 1 && g(0, 0, from_s) == 0) && lim < 4 * PER) begin
            prev = g(0, 0, from_s);
            @(negedge clk);
            lim++;
        end
        k = 0;
        while (g(0, 0, to_s) == 0 && g(0, 0, from_s) == 0 && k < 100) begin
            k++;
            @(negedge clk);
        end
    endtask

    // R9: blanking length and no overlap.
    task automatic t_dead();
        int k;
        int both = 0;
        dead = 8'd3;
        idle(PER);
        measure_blank(0, 1, k);
        check("R9 upper-to-lower blank with dead 3", k, 3);
        measure_blank(1, 0, k);
        check("R9 lower-to-upper blank with dead 3", k, 3);
        dead = 8'd0;
        idle(PER);
        measure_blank(0, 1, k);
        check("R9 blank with dead 0 is one clock", k, 1);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            for (int p = 0; p < PH; p++)
                for (int m = 0; m < MD; m++)
                    if ((g(p, m, 0) && g(p, m, 1)) || (g(p, m, 2) && g(p, m, 3))) both++;
        end
        check("R9 no leg with both gates on", both, 0);
    endtask

    // R10 and R1: trip and enable behaviour.
    task automatic t_trip();
        int held = 0;
        dead = 8'd2;
        idle(PER);
        trip = 1'b1;
        @(negedge clk);
        check("R10 gates off one clock after trip", $countones(gates), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            held += $countones(gates);
        end
        check("R10 gates held off during trip", held, 0);
        trip = 1'b0;
        @(negedge clk);
        check("R10 first clock after clear still blank", $countones(gates), 0);
        @(negedge clk);
        check("R10 second clock after clear still blank", $countones(gates), 0);
        @(negedge clk);
        check("R10 one gate per leg after blanking", $countones(gates), PH * MD * 2);
        enable = 1'b0;
        @(negedge clk);
        check("R1 enable low turns gates off", $countones(gates), 0);
    endtask

    initial begin
        t_reset();
        t_zero_ref();
        t_shadow();
        t_sat_sync();
        t_levels();
        t_ripple_shift();
        t_dead();
        t_trip();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule